// File: doc/BRIEF.md
# Board Address Decoder with Timed Acknowledge

This block sits on a processor board and turns each 16-bit bus address into chip selects. A selectable 8K block of the address space holds four 1K ROM windows and a 32-byte group of memory-mapped I/O devices. RAM occupies whichever 16K blocks a strap enables. Straps are static wiring: a one-hot byte picks the 8K block for the ROM and I/O group, one bit picks the half of that block that the ROM windows use, and a four-bit mask enables the RAM blocks. An active-low inhibit input lets another board claim addresses that RAM would otherwise answer.

The block also returns the two bus acknowledges. When the target is not RAM, a local counter drives the advance acknowledge and then the transfer acknowledge a fixed number of clock cycles after the device select asserts. When RAM is selected, both acknowledges follow the RAM controller's outputs instead. Every select and acknowledge output is active-low and comes straight from a register, so address changes cannot glitch them.

Top module: `board_addr_decode`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, every select output and both acknowledge outputs are high.
- R2: Each select output reflects the address and straps sampled on the previous rising clock edge. The ROM windows lie only in the 8K block `addr[15:13]` whose bit in `rom_blk_sel` is set; inside the active 4K half, `rom_sel_n[addr[11:10]]` goes low.
- R3: The ROM half is the upper 4K of the chosen 8K block (`addr[12]` = 1) when `rom_upper` is 1, and the lower 4K (`addr[12]` = 0) when it is 0. Addresses in the other half select nothing.
- R4: `ram_sel_n` goes low exactly when bit `addr[15:14]` of `ram_blk_en` is set and `ram_inhibit_n` is high. This does not depend on the ROM and I/O decode.
- R5: In window 3, offsets 0x3E0 to 0x3FF (`addr[9:5]` all ones) drive `io_sel_n[addr[4:2]]` low instead of `rom_sel_n[3]`. Each I/O device therefore covers four consecutive addresses, and ROM 3 keeps 992 bytes.
- R6: At most one of the twelve ROM and I/O select outputs is low in any cycle.
- R7: When RAM is not selected, `aack_n` goes low `AACK_CYC` clock cycles after a ROM or I/O select output goes low, and `xack_n` goes low `XACK_CYC` cycles after it. Both are high whenever no ROM or I/O select is low. The defaults are 25 and 50 cycles, which is 500 ns and 1000 ns at 50 MHz.
- R8: While `ram_sel_n` is low, `aack_n` and `xack_n` equal `ramc_aack_n` and `ramc_xack_n` as sampled on the previous rising edge.
- R9: The acknowledge delay restarts only after every ROM and I/O select has gone high. Moving straight from one ROM or I/O select to another does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| rom_blk_sel | input | 8 | One-hot strap: the 8K block that holds the ROMs and I/O |
| ram_blk_en | input | 4 | Strap: one bit per 16K block that holds RAM |
| rom_upper | input | 1 | Strap: 1 puts the ROM windows in the upper 4K, 0 in the lower 4K |
| ram_inhibit_n | input | 1 | Active-low RAM inhibit from the bus |
| ramc_aack_n | input | 1 | Advance acknowledge from the RAM controller |
| ramc_xack_n | input | 1 | Transfer acknowledge from the RAM controller |
| ram_sel_n | output | 1 | RAM controller select, active low |
| rom_sel_n | output | 4 | ROM window selects, active low |
| io_sel_n | output | 8 | I/O device selects, active low |
| aack_n | output | 1 | Advance acknowledge to the bus, active low |
| xack_n | output | 1 | Transfer acknowledge to the bus, active low |

## Verification
The bench targets the edges of the I/O carve-out in the fourth window: 0x3DF must still select ROM 3 and 0x3E0 must select I/O device 0. A design that mishandles this either lets ROM 3 answer alongside an I/O device or loses the last ROM bytes. It holds a non-RAM select for long runs to find the exact cycles where the two acknowledges fall; an off-by-one counter shifts them by a cycle. It changes the address between two non-RAM selects with no gap, which catches a counter that restarts there. It also overlaps RAM with the ROM block and asserts the inhibit input, to show that the acknowledge source follows the RAM select and that inhibit removes it.

// File: rtl/bd_pkg.sv
package bd_pkg;
    localparam int ADDR_W   = 16;
    localparam int NUM_8K   = 8;
    localparam int NUM_16K  = 4;
    localparam int NUM_ROM  = 4;
    localparam int NUM_IO   = 8;
    localparam int WIN_BITS = $clog2(NUM_ROM);
    localparam int IO_BITS  = $clog2(NUM_IO);

    // Active-high select set produced by the decoder and held in registers.
    typedef struct packed {
        logic               ram;
        logic [NUM_ROM-1:0] rom;
        logic [NUM_IO-1:0]  io;
    } sel_t;

    function automatic logic local_hit(sel_t s);
        return (|s.rom) | (|s.io);
    endfunction
endpackage

// File: rtl/bd_region_decode.sv
module bd_region_decode
    import bd_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_8K-1:0]  rom_blk_sel,
    input  logic [NUM_16K-1:0] ram_blk_en,
    input  logic               rom_upper,
    input  logic               ram_inhibit_n,
    output sel_t               sel
);
    logic                in_blk;
    logic                in_half;
    logic                io_hit;
    logic [WIN_BITS-1:0] win;
    logic [IO_BITS-1:0]  dev;

    assign in_blk  = rom_blk_sel[addr[15:13]];
    assign in_half = in_blk && (addr[12] == rom_upper);
    assign win     = addr[11:10];
    assign dev     = addr[4:2];
    // Top 32 bytes of the last window go to I/O.
    assign io_hit  = in_half && (win == WIN_BITS'(NUM_ROM-1)) && (&addr[9:5]);

    always_comb begin
        sel     = '0;
        sel.ram = ram_blk_en[addr[15:14]] & ram_inhibit_n;
        for (int i = 0; i < NUM_ROM; i++)
            sel.rom[i] = in_half && !io_hit && (win == WIN_BITS'(i));
        for (int j = 0; j < NUM_IO; j++)
            sel.io[j] = io_hit && (dev == IO_BITS'(j));
    end
endmodule

// File: rtl/bd_ack_timer.sv
module bd_ack_timer #(
    parameter int AACK_CYC = 25,
    parameter int XACK_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic local_d,
    input  logic ram_d,
    input  logic ramc_aack_n,
    input  logic ramc_xack_n,
    output logic aack_n,
    output logic xack_n
);
    localparam int CNT_MAX = XACK_CYC + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] CMAX = CW'(CNT_MAX);
    localparam logic [CW-1:0] ATHR = CW'(AACK_CYC);
    localparam logic [CW-1:0] XTHR = CW'(XACK_CYC);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          local_q;
    logic          aack_d, xack_d;

    always_comb begin
        if (!local_d)
            cnt_d = '0;
        else if (!local_q)
            cnt_d = CW'(1);
        else if (cnt_q != CMAX)
            cnt_d = cnt_q + CW'(1);
        else
            cnt_d = cnt_q;
    end

    always_comb begin
        if (ram_d) begin
            aack_d = ramc_aack_n;
            xack_d = ramc_xack_n;
        end else begin
            aack_d = !(local_d && (cnt_d > ATHR));
            xack_d = !(local_d && (cnt_d > XTHR));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            local_q <= 1'b0;
            aack_n  <= 1'b1;
            xack_n  <= 1'b1;
        end else begin
            cnt_q   <= cnt_d;
            local_q <= local_d;
            aack_n  <= aack_d;
            xack_n  <= xack_d;
        end
    end
endmodule

// File: rtl/board_addr_decode.sv
module board_addr_decode
    import bd_pkg::*;
#(
    parameter int AACK_CYC = 25,
    parameter int XACK_CYC = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic [7:0]  rom_blk_sel,
    input  logic [3:0]  ram_blk_en,
    input  logic        rom_upper,
    input  logic        ram_inhibit_n,
    input  logic        ramc_aack_n,
    input  logic        ramc_xack_n,
    output logic        ram_sel_n,
    output logic [3:0]  rom_sel_n,
    output logic [7:0]  io_sel_n,
    output logic        aack_n,
    output logic        xack_n
);
    sel_t sel_d, sel_q;

    bd_region_decode u_dec (
        .addr          (addr),
        .rom_blk_sel   (rom_blk_sel),
        .ram_blk_en    (ram_blk_en),
        .rom_upper     (rom_upper),
        .ram_inhibit_n (ram_inhibit_n),
        .sel           (sel_d)
    );

    bd_ack_timer #(
        .AACK_CYC (AACK_CYC),
        .XACK_CYC (XACK_CYC)
    ) u_ack (
        .clk         (clk),
        .rst         (rst),
        .local_d     (local_hit(sel_d)),
        .ram_d       (sel_d.ram),
        .ramc_aack_n (ramc_aack_n),
        .ramc_xack_n (ramc_xack_n),
        .aack_n      (aack_n),
        .xack_n      (xack_n)
    );

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_d;
    end

    assign ram_sel_n = ~sel_q.ram;
    assign rom_sel_n = ~sel_q.rom;
    assign io_sel_n  = ~sel_q.io;
endmodule

// File: rtl/board_addr_decode_chk.sv
module board_addr_decode_chk #(
    parameter int AACK_CYC = 25,
    parameter int XACK_CYC = 50
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic        ram_inhibit_n,
    input logic        ramc_aack_n,
    input logic        ramc_xack_n,
    input logic        ram_sel_n,
    input logic [3:0]  rom_sel_n,
    input logic [7:0]  io_sel_n,
    input logic        aack_n,
    input logic        xack_n
);
    logic loc;
    int   age;

    assign loc = !(&{rom_sel_n, io_sel_n});

    // Cycles a ROM/I-O select has already been low before this one.
    always_ff @(posedge clk) begin
        if (rst || !loc) age <= 0;
        else if (age <= XACK_CYC) age <= age + 1;
    end

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~{rom_sel_n, io_sel_n}));

    // R7
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_sel_n && !loc) |-> (aack_n && xack_n));

    // R7
    aack_early_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_sel_n && loc && age < AACK_CYC) |-> aack_n);

    // R7
    aack_due_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_sel_n && loc && age >= AACK_CYC) |-> !aack_n);

    // R7
    xack_early_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_sel_n && loc && age < XACK_CYC) |-> xack_n);

    // R7
    xack_due_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_sel_n && loc && age >= XACK_CYC) |-> !xack_n);

    // R8
    ram_ack_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_sel_n |-> (aack_n == $past(ramc_aack_n) && xack_n == $past(ramc_xack_n)));

    // R4
    ram_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_sel_n |-> $past(ram_inhibit_n));

    // R5
    io_carve_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&io_sel_n)) |-> ($past(addr[11:5]) == 7'h7f && rom_sel_n[3]));
endmodule

bind board_addr_decode board_addr_decode_chk #(
    .AACK_CYC (AACK_CYC),
    .XACK_CYC (XACK_CYC)
) u_chk (.*);

// File: tb/test_board_addr_decode.sv
module test_board_addr_decode;
    localparam int AACK = 25;
    localparam int XACK = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  rom_blk_sel = 8'b0000_0100;
    logic [3:0]  ram_blk_en = 4'b1001;
    logic        rom_upper = 1'b1;
    logic        ram_inhibit_n = 1'b1;
    logic        ramc_aack_n = 1'b1;
    logic        ramc_xack_n = 1'b1;
    logic        ram_sel_n, aack_n, xack_n;
    logic [3:0]  rom_sel_n;
    logic [7:0]  io_sel_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    board_addr_decode i_board_addr_decode (
        .clk(clk), .rst(rst), .addr(addr), .rom_blk_sel(rom_blk_sel),
        .ram_blk_en(ram_blk_en), .rom_upper(rom_upper), .ram_inhibit_n(ram_inhibit_n),
        .ramc_aack_n(ramc_aack_n), .ramc_xack_n(ramc_xack_n), .ram_sel_n(ram_sel_n),
        .rom_sel_n(rom_sel_n), .io_sel_n(io_sel_n), .aack_n(aack_n), .xack_n(xack_n)
    );

    // Reference decode: bit 12 RAM, bits 11:8 ROM 3..0, bits 7:0 I/O 7..0.
    function automatic logic [12:0] ref_dec(int a);
        logic [12:0] r = '0;
        int blk = a / 8192;
        int off = a % 8192;
        int win = (off % 4096) / 1024;
        int wo  = off % 1024;
        if (ram_blk_en[a / 16384] && ram_inhibit_n) r[12] = 1'b1;
        if (rom_blk_sel[blk] && (off / 4096) == (rom_upper ? 1 : 0)) begin
            if (win == 3 && wo >= 992) r[(wo - 992) / 4] = 1'b1;
            else r[8 + win] = 1'b1;
        end
        return r;
    endfunction

    logic [12:0] e_sel = '0;
    logic        e_aack = 1'b1, e_xack = 1'b1, e_loc = 1'b0, e_rst = 1'b1;
    int          run = 0;

    always @(posedge clk) begin
        logic [12:0] r;
        logic        l;
        int          nr;
        e_rst <= rst;
        if (rst) begin
            e_sel <= '0; e_aack <= 1'b1; e_xack <= 1'b1; e_loc <= 1'b0; run <= 0;
        end else begin
            r  = ref_dec(int'(addr));
            l  = |r[11:0];
            nr = l ? (e_loc ? run + 1 : 1) : 0;
            e_sel <= r;
            e_loc <= l;
            run   <= nr;
            e_aack <= r[12] ? ramc_aack_n : !(l && nr > AACK);
            e_xack <= r[12] ? ramc_xack_n : !(l && nr > XACK);
        end
    end

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d addr=%h: actual=%h expected=%h",
                     tag, what, cyc, addr, act, exp);
        end
    endtask

    // Compare every clock, away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        if (e_rst) begin
            chk("R1", "reset outputs", {ram_sel_n, aack_n, xack_n, &rom_sel_n, &io_sel_n, 3'b111},
                8'hff);
        end else begin
            chk("R4", "ram_sel_n", {7'd0, ram_sel_n}, {7'd0, !e_sel[12]});
            chk("R2/R3", "rom_sel_n", {4'd0, rom_sel_n}, {4'd0, ~e_sel[11:8]});
            chk("R5", "io_sel_n", io_sel_n, ~e_sel[7:0]);
            chk(e_sel[12] ? "R8" : "R7/R9", "aack_n", {7'd0, aack_n}, {7'd0, e_aack});
            chk(e_sel[12] ? "R8" : "R7/R9", "xack_n", {7'd0, xack_n}, {7'd0, e_xack});
            chk("R6", "low select count <= 1",
                {7'd0, ($countones(~{rom_sel_n, io_sel_n}) <= 1)}, 8'd1);
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic hold(logic [15:0] a, int n);
        @(negedge clk);
        addr = a;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hold(16'h8000, 5);            // nothing decoded
        hold(16'h5000, 60);           // ROM 0, full acknowledge run (R7)
        hold(16'h8000, 3);
        hold(16'h5FE4, 60);           // I/O 1 (R5)
        hold(16'h5FDF, 10);           // last ROM 3 byte
        hold(16'h5FE0, 10);           // first I/O byte
        hold(16'h5FFF, 10);           // I/O 7
        hold(16'h4000, 10);           // wrong half (R3)
        @(negedge clk); rom_upper = 1'b0;
        hold(16'h4400, 30);           // ROM 1 in lower half (R3)
        hold(16'h4FFC, 30);           // I/O 7 in lower half
        hold(16'h5000, 5);            // now wrong half
        @(negedge clk); rom_upper = 1'b1;
        hold(16'h5000, 15);           // back-to-back, no gap (R9)
        hold(16'h5400, 45);
        hold(16'h5FE8, 10);
        hold(16'hC123, 3);            // RAM (R4, R8)
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); ramc_aack_n = k[0]; ramc_xack_n = k[1];
        end
        @(negedge clk); ram_inhibit_n = 1'b0;   // inhibit removes RAM (R4)
        hold(16'hC123, 5);
        @(negedge clk); ram_inhibit_n = 1'b1; ram_blk_en = 4'b0110;
        hold(16'h5800, 20);           // RAM overlapping ROM block (R8)
        for (int a = 16'h5F00; a < 16'h6000; a += 4) hold(16'(a), 1);
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) addr = {3'b010, lfsr[15:3]};
            else if (lfsr[1]) addr = lfsr;
            ramc_aack_n = lfsr[5];
            ramc_xack_n = lfsr[6];
            if (k % 500 == 0) begin
                rom_upper     = lfsr[7];
                ram_blk_en    = lfsr[11:8];
                ram_inhibit_n = lfsr[12] | lfsr[13];
                rom_blk_sel   = 8'b1 << lfsr[2:0];
            end
            if (lfsr[3:2] == 2'b00) repeat (60) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule